// File: doc/BRIEF.md
# Serial Port Register and FIFO Front-End

This block sits between a simple word-wide register bus and the shift engine of a synchronous serial port. It holds one control register and one 16-bit data window. A bus write to the data window pushes a word into a transmit FIFO. A bus read of the data window pops a word from a receive FIFO. The shift engine sits outside this block. It drains the transmit FIFO through a pop strobe and fills the receive FIFO through a push strobe. It also reads four control bits directly: port enable, slave select, internal loopback and slave output disable.

Data passes through the FIFOs whether or not the port is enabled. Software can therefore queue transmit words before it turns the port on. Turning the port off leaves both queues as they are. The slave select bit is locked while the port runs.

The transmit word seen by the engine is right-justified to the active frame length, and the bits above that length are forced to zero. In the three-wire command mode (microwire frames), the transmit word is always the low byte. The frame length and the microwire mode come in from a neighbouring configuration register.

Top module: `ssp_regfront`

## Requirements
- R1: After reset every control bit is 0, the control register reads 0x0000, both FIFOs are empty and neither is full.
- R2: The control register is at bus address 0. Bit 0 is loopback, bit 1 is port enable, bit 2 is slave select (0 = master) and bit 3 is slave output disable. Bits 15:4 read 0 and ignore writes.
- R3: A control write leaves the slave select bit unchanged if the port enable bit was 1 before that write. This applies even when the same write clears the enable bit.
- R4: A bus write to address 1 pushes the written word into the transmit FIFO. The engine receives the words in the order they were written, one word per tx_pop.
- R5: Each FIFO holds 8 words and raises its full flag when it holds 8. A push into a full FIFO is dropped, and the stored words are kept.
- R6: A bus read of address 1 pops the oldest receive word. bus_rdata shows the result from the clock edge that samples bus_rd, and holds it until the next read.
- R7: A bus read of address 1 while the receive FIFO is empty returns 0 and leaves the FIFO unchanged.
- R8: Clearing the port enable bit does not remove words from either FIFO.
- R9: With frame length L = cfg_len_m1 + 1 and cfg_microwire = 0, tx_data equals the head word with bits 15:L forced to 0.
- R10: With cfg_microwire = 1, tx_data equals the low byte of the head word, and bits 15:8 are 0 whatever cfg_len_m1 holds.
- R11: A push and a pop on the same FIFO in the same cycle both take effect. The popped word is the old head, and the word count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register word address (0 control, 1 data) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| cfg_len_m1 | input | 4 | Frame length minus one |
| cfg_microwire | input | 1 | Microwire frame mode, 8-bit transmit |
| ctl_loopback | output | 1 | Loopback control bit |
| ctl_enable | output | 1 | Port enable control bit |
| ctl_slave | output | 1 | Slave select control bit |
| ctl_sod | output | 1 | Slave output disable control bit |
| tx_data | output | 16 | Masked head of the transmit FIFO |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| tx_pop | input | 1 | Engine takes the transmit head |
| rx_wdata | input | 16 | Received word from the engine |
| rx_push | input | 1 | Engine stores a received word |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |

## Verification
The bus and the shift engine reach the same queue from two sides, so a bus push can meet an engine pop, and an engine push can meet a bus pop, on the same clock edge. The bench drives both strobes in a single cycle. It first drives them against a partly filled queue. It then drives an engine push together with a read of an empty receive queue. A scoreboard queue judges both cases: the popped word must be the old head, and later pops must come out in order with nothing lost or duplicated.

// File: rtl/ssp_front_pkg.sv
package ssp_front_pkg;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_DATA = 1;

  // Control bits; packed order puts loopback at bit 0, up to output disable at bit 3
  typedef struct packed {
    logic sod;
    logic slave;
    logic enable;
    logic loopback;
  } ctrl_t;

  // Keep bits [len_m1:0]; microwire keeps the low byte only
  function automatic logic [15:0] frame_mask(input logic [3:0] len_m1, input logic mw);
    logic [15:0] m;
    m = 16'hFFFF >> (4'd15 - len_m1);
    if (mw) m = 16'h00FF;
    return m;
  endfunction

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       push_ok,
  output logic                       pop_ok
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/ssp_ctrl_reg.sv
module ssp_ctrl_reg
  import ssp_front_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wdata,
  output ctrl_t      q,
  output logic       slave_locked
);
  assign slave_locked = q.enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en) begin
      q.loopback <= wdata[0];
      q.enable   <= wdata[1];
      q.sod      <= wdata[3];
      if (!slave_locked) q.slave <= wdata[2];
    end
  end
endmodule

// File: rtl/ssp_regfront.sv
module ssp_regfront
  import ssp_front_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [3:0]        cfg_len_m1,
  input  logic              cfg_microwire,
  output logic              ctl_loopback,
  output logic              ctl_enable,
  output logic              ctl_slave,
  output logic              ctl_sod,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_empty,
  output logic              tx_full,
  input  logic              tx_pop,
  input  logic [DATA_W-1:0] rx_wdata,
  input  logic              rx_push,
  output logic              rx_empty,
  output logic              rx_full
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  ctrl_t             ctrl_q;
  logic              slave_locked;
  logic              sel_ctrl, sel_data;
  logic              ctrl_wr, data_wr, data_rd;
  logic [DATA_W-1:0] tx_head, rx_head;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;

  assign sel_ctrl = (bus_addr == ADDR_W'(ADDR_CTRL));
  assign sel_data = (bus_addr == ADDR_W'(ADDR_DATA));
  assign ctrl_wr  = bus_wr && sel_ctrl;
  assign data_wr  = bus_wr && sel_data;
  assign data_rd  = bus_rd && sel_data;

  ssp_ctrl_reg u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (ctrl_wr),
    .wdata        (bus_wdata[3:0]),
    .q            (ctrl_q),
    .slave_locked (slave_locked)
  );

  assign ctl_loopback = ctrl_q.loopback;
  assign ctl_enable   = ctrl_q.enable;
  assign ctl_slave    = ctrl_q.slave;
  assign ctl_sod      = ctrl_q.sod;

  ssp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk (clk), .rst_n (rst_n),
    .push (data_wr), .wdata (bus_wdata),
    .pop (tx_pop), .head (tx_head),
    .full (tx_full), .empty (tx_empty), .count (tx_cnt),
    .push_ok (tx_push_ok), .pop_ok (tx_pop_ok)
  );

  ssp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk (clk), .rst_n (rst_n),
    .push (rx_push), .wdata (rx_wdata),
    .pop (data_rd), .head (rx_head),
    .full (rx_full), .empty (rx_empty), .count (rx_cnt),
    .push_ok (rx_push_ok), .pop_ok (rx_pop_ok)
  );

  assign tx_data = tx_head & DATA_W'(frame_mask(cfg_len_m1, cfg_microwire));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (sel_ctrl)      bus_rdata <= DATA_W'(ctrl_q);
      else if (sel_data) bus_rdata <= rx_empty ? '0 : rx_head;
      else               bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/ssp_regfront_chk.sv
module ssp_regfront_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_wr,
  input logic          data_wr,
  input logic          data_rd,
  input logic [3:0]    wbits,
  input logic          ctl_enable,
  input logic          ctl_slave,
  input logic          tx_pop,
  input logic          tx_full,
  input logic          tx_empty,
  input logic          rx_push,
  input logic          rx_full,
  input logic          rx_empty,
  input logic          cfg_microwire,
  input logic [15:0]   tx_data,
  input logic [15:0]   bus_rdata,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  p_slave_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctl_enable) |=> $stable(ctl_slave));

  p_tx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));

  p_rx_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rx_push && !data_rd) |=> (rx_full && rx_cnt == CW'(DEPTH)));

  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty) && !(rx_full && rx_empty));

  p_empty_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && rx_empty) |=> (bus_rdata == 16'h0000));

  p_disable_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wbits[1] && !tx_pop) |=> (tx_cnt == $past(tx_cnt)));

  p_microwire_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_microwire |-> (tx_data[15:8] == 8'h00));

  p_same_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && tx_pop && !tx_full && !tx_empty) |=> $stable(tx_cnt));
endmodule

bind ssp_regfront ssp_regfront_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk (clk), .rst_n (rst_n),
  .ctrl_wr (ctrl_wr), .data_wr (data_wr), .data_rd (data_rd),
  .wbits (bus_wdata[3:0]),
  .ctl_enable (ctl_enable), .ctl_slave (ctl_slave),
  .tx_pop (tx_pop), .tx_full (tx_full), .tx_empty (tx_empty),
  .rx_push (rx_push), .rx_full (rx_full), .rx_empty (rx_empty),
  .cfg_microwire (cfg_microwire), .tx_data (tx_data),
  .bus_rdata (bus_rdata), .tx_cnt (tx_cnt), .rx_cnt (rx_cnt)
);

// File: tb/ssp_regfront_tb_top.sv
module ssp_regfront_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  cfg_len_m1 = 4'd15;
  logic        cfg_microwire = 1'b0;
  logic        ctl_loopback, ctl_enable, ctl_slave, ctl_sod;
  logic [15:0] tx_data;
  logic        tx_empty, tx_full, rx_empty, rx_full;
  logic        tx_pop = 1'b0, rx_push = 1'b0;
  logic [15:0] rx_wdata = '0;

  int checks = 0;
  int fails  = 0;
  logic [15:0] txq[$];
  logic [15:0] rxq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ssp_regfront dut_i (.*);

  function automatic logic [15:0] exp_mask(input int len_m1, input bit mw);
    if (mw) return 16'h00FF;
    return 16'((32'h1 << (len_m1 + 1)) - 1);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // Driver: push to the design and to the scoreboard
  task automatic drv_tx(input logic [15:0] d);
    bus_write(2'd1, d);
    if (txq.size() < 8) txq.push_back(d);
  endtask

  // Monitor: engine pop, compare against scoreboard head
  task automatic mon_tx(input string req);
    logic [15:0] e;
    @(negedge clk);
    e = (txq.size() > 0) ? txq.pop_front() : 16'hDEAD;
    check(req, tx_data, e & exp_mask(cfg_len_m1, cfg_microwire));
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic eng_rx(input logic [15:0] d);
    @(negedge clk);
    rx_wdata = d; rx_push = 1'b1;
    @(negedge clk);
    rx_push = 1'b0;
    if (rxq.size() < 8) rxq.push_back(d);
  endtask

  task automatic mon_rx(input string req);
    logic [15:0] d, e;
    e = (rxq.size() > 0) ? rxq.pop_front() : 16'h0000;
    bus_read(2'd1, d);
    check(req, d, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctl bits", {12'h0, ctl_sod, ctl_slave, ctl_enable, ctl_loopback}, 16'h0);
    check("R1 flags", {12'h0, tx_empty, tx_full, rx_empty, rx_full}, 16'h000A);
    bus_read(2'd0, r); check("R1 ctrl read", r, 16'h0000);

    // R2 bit positions and reserved bits
    bus_write(2'd0, 16'hFFFF); bus_read(2'd0, r); check("R2 all set", r, 16'h000F);
    bus_write(2'd0, 16'h0000); bus_write(2'd0, 16'h0000);
    bus_write(2'd0, 16'h0001); check("R2 loopback bit0", {15'h0, ctl_loopback}, 16'h1);
    bus_write(2'd0, 16'h0002); check("R2 enable bit1", {15'h0, ctl_enable}, 16'h1);
    bus_write(2'd0, 16'h0000);
    bus_write(2'd0, 16'h0004); check("R2 slave bit2", {15'h0, ctl_slave}, 16'h1);
    bus_write(2'd0, 16'h0008); bus_read(2'd0, r); check("R2 sod bit3 slave clear", r, 16'h0008);

    // R3 slave select locked while enabled
    bus_write(2'd0, 16'h0006); bus_read(2'd0, r); check("R3 set with enable", r, 16'h0006);
    bus_write(2'd0, 16'h0002); bus_read(2'd0, r); check("R3 clear ignored", r, 16'h0006);
    bus_write(2'd0, 16'h0000); bus_read(2'd0, r); check("R3 same-write disable", r, 16'h0004);
    bus_write(2'd0, 16'h0000); bus_read(2'd0, r); check("R3 unlocked", r, 16'h0000);

    // R4, R8 preload while disabled, enable, disable, then drain
    drv_tx(16'h1111); drv_tx(16'h2222); drv_tx(16'h3333);
    bus_write(2'd0, 16'h0002); bus_write(2'd0, 16'h0000);
    check("R8 not flushed", {15'h0, tx_empty}, 16'h0);
    mon_tx("R4 order"); mon_tx("R8 order"); mon_tx("R4 order");
    check("R4 empty after drain", {15'h0, tx_empty}, 16'h1);

    // R5 transmit full and drop
    for (int i = 0; i < 9; i++) drv_tx(16'hA000 + 16'(i));
    check("R5 tx full", {15'h0, tx_full}, 16'h1);
    for (int i = 0; i < 8; i++) mon_tx("R5 tx drop");
    check("R5 tx empty", {15'h0, tx_empty}, 16'h1);

    // R9, R10 masking
    cfg_len_m1 = 4'd7;  drv_tx(16'hABCD); mon_tx("R9 len8");
    cfg_len_m1 = 4'd3;  drv_tx(16'hABCD); mon_tx("R9 len4");
    cfg_len_m1 = 4'd0;  drv_tx(16'hFFFF); mon_tx("R9 len1");
    cfg_len_m1 = 4'd15; cfg_microwire = 1'b1; drv_tx(16'hBEEF); mon_tx("R10 microwire");
    cfg_len_m1 = 4'd3;  drv_tx(16'h1234); mon_tx("R10 microwire short len");
    cfg_microwire = 1'b0; cfg_len_m1 = 4'd15;

    // R6, R7 receive path
    eng_rx(16'h0A0A); eng_rx(16'h0B0B); eng_rx(16'h0C0C);
    mon_rx("R6 rx order"); mon_rx("R6 rx order"); mon_rx("R6 rx order");
    mon_rx("R7 empty read");
    eng_rx(16'h5A5A); mon_rx("R7 pointer kept");
    bus_read(2'd1, r); check("R6 hold reads", bus_rdata, 16'h0000);

    // R5 receive full
    for (int i = 0; i < 9; i++) eng_rx(16'hC000 + 16'(i));
    check("R5 rx full", {15'h0, rx_full}, 16'h1);
    for (int i = 0; i < 8; i++) mon_rx("R5 rx drop");
    mon_rx("R5 rx empty after drain");

    // R11 same-cycle push and pop on transmit
    drv_tx(16'h7001); drv_tx(16'h7002);
    @(negedge clk);
    check("R11 tx old head", tx_data, txq[0]);
    bus_addr = 2'd1; bus_wdata = 16'h7003; bus_wr = 1'b1; tx_pop = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tx_pop = 1'b0;
    void'(txq.pop_front()); txq.push_back(16'h7003);
    mon_tx("R11 tx order"); mon_tx("R11 tx order");
    check("R11 tx empty", {15'h0, tx_empty}, 16'h1);

    // R11 same-cycle push and pop on receive
    eng_rx(16'h6001);
    @(negedge clk);
    bus_addr = 2'd1; bus_rd = 1'b1; rx_wdata = 16'h6002; rx_push = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; rx_push = 1'b0;
    check("R11 rx old head", bus_rdata, 16'h6001);
    void'(rxq.pop_front()); rxq.push_back(16'h6002);
    mon_rx("R11 rx order");
    mon_rx("R7 empty after same-cycle");

    // R7 read of empty receive queue meets an engine push
    @(negedge clk);
    bus_addr = 2'd1; bus_rd = 1'b1; rx_wdata = 16'h4444; rx_push = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; rx_push = 1'b0;
    check("R7 empty read with push", bus_rdata, 16'h0000);
    rxq.push_back(16'h4444);
    mon_rx("R11 push kept");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule